// File: doc/BRIEF.md
# Crosspoint Switch Configuration Register

This block is the digital control path of a 16 by 16 analog crosspoint. A configuration frame arrives as a serial bit stream, qualified by an external serial clock. Each rising edge of that clock pushes one bit into a 256-stage chain. When the frame is complete, the host drives an active-low transfer strobe, and the chain is copied into a bank of static latches. Each latch bit closes (1) or opens (0) one row/column intersection of the connect matrix. The far end of the chain is brought out as a serial output, so several blocks can be daisy-chained on one serial line.

All three serial-side inputs are synchronized into the system clock. Edges are detected from the synchronized samples. The chain models a dynamic store, so it has a retention window. Once a full frame has been shifted in, the transfer must complete within a parameterized number of system cycles. Otherwise a stale flag is raised and the transfer is refused. Any further serial edge refreshes the chain and clears the flag.

Top module: `xbar_cfg_top`

## Requirements
- R1: When reset is held, the connect matrix is cleared to all zeros (every switch open), the serial output is 0 and the stale flag is 0. The chain is also zeroed.
- R2: Each rising edge of the serial clock (seen after SYNC_STAGES synchronizer flops) shifts exactly one bit into the chain. While no such edge occurs, the chain content is unchanged.
- R3: Within a 256-bit frame, the bit loaded k-th (k = 0 first) controls row 15 - k/16 and column 15 - k%16. On `connect_o`, row r / column c is bit r*16 + c. A value of 1 closes the switch.
- R4: The serial output shows the bit shifted in 255 edges before the most recent one. This is the bit 256 edges old at the time the next bit is presented. Until enough edges have occurred after reset, it shows 0.
- R5: While the synchronized strobe is low and the stale flag is 0, the latches follow the chain content. Bits shifted while the strobe is held low therefore reach the matrix.
- R6: While the synchronized strobe is high, the matrix holds its value, whatever happens on the serial input.
- R7: The chain counts as filled after 256 serial edges since the last strobe release (or since reset). From then on, if HOLD_LIMIT system cycles pass with no serial edge and no strobe release, the stale flag is set.
- R8: While the stale flag is set, a low strobe does not change the matrix.
- R9: The next serial edge clears the stale flag and restarts the retention window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous; idles high |
| ser_dat_i | input | 1 | Serial configuration data |
| xfer_n_i | input | 1 | Active-low transfer strobe, asynchronous |
| ser_dat_o | output | 1 | Tail of the chain, for cascading |
| connect_o | output | ROWS*COLS | Latched connect matrix, bit row*COLS+col |
| stale_o | output | 1 | Chain contents expired; transfer blocked |

## Verification
Several properties are checked on every cycle by the assertions. The chain is frozen between serial edges, and each edge captures the synchronized data bit. The matrix is frozen whenever the strobe is high or the stale flag is set. A serial edge always clears the stale flag, and reset leaves everything cleared. Other behaviours need multi-thousand-cycle scenarios from the bench. These are the row-major, highest-first frame mapping, the 256-edge serial output delay, level-following transfer with the strobe held low, and stale flag expiry after HOLD_LIMIT idle cycles. The bench runs them against its behavioural model.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    // Raw serial-side pins bundled for synchronization
    typedef struct packed {
        logic sclk;
        logic sdat;
        logic strobe_n;
    } ser_pins_t;

    // Idle levels: both clocks high is a no-op
    localparam ser_pins_t PINS_IDLE = '{sclk: 1'b1, sdat: 1'b0, strobe_n: 1'b1};

    // Qualified controls in the system clock domain
    typedef struct packed {
        logic shift;       // one serial rising edge seen
        logic shift_bit;   // data aligned to that edge
        logic strobe_low;  // synchronized strobe level is low
        logic release_evt; // strobe went low -> high
    } ser_ctl_t;

    function automatic int cell_index(input int row, input int col, input int cols);
        return row * cols + col;
    endfunction

endpackage

// File: rtl/xbar_in_sync.sv
module xbar_in_sync
    import xbar_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  ser_pins_t pins_i,
    output ser_ctl_t  ctl_o
);
    ser_pins_t stage_q [STAGES];
    ser_pins_t last_q;
    ser_pins_t cur;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= PINS_IDLE;
                else     stage_q[i] <= pins_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= PINS_IDLE;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign cur = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) last_q <= PINS_IDLE;
        else     last_q <= cur;
    end

    always_comb begin
        ctl_o.shift       = cur.sclk & ~last_q.sclk;
        ctl_o.shift_bit   = cur.sdat;
        ctl_o.strobe_low  = ~cur.strobe_n;
        ctl_o.release_evt = cur.strobe_n & ~last_q.strobe_n;
    end

endmodule

// File: rtl/xbar_shift_chain.sv
module xbar_shift_chain #(
    parameter int DEPTH = 256
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [DEPTH-1:0] chain_o,
    output logic             tail_o
);
    always_ff @(posedge clk) begin
        if (rst)          chain_o <= '0;
        else if (shift_i) chain_o <= {chain_o[DEPTH-2:0], bit_i};
    end

    assign tail_o = chain_o[DEPTH-1];

    // R2: no serial edge, no movement
    assert_chain_frozen_R2: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(chain_o));
    // R2: an edge captures the presented bit at the head
    assert_chain_capture_R2: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (chain_o[0] == $past(bit_i)));

endmodule

// File: rtl/xbar_hold_timer.sv
module xbar_hold_timer #(
    parameter int DEPTH = 256,
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic shift_i,
    input  logic release_i,
    output logic stale_o
);
    localparam int FILL_W = $clog2(DEPTH + 1);
    localparam int AGE_W  = $clog2(LIMIT + 1);

    logic [FILL_W-1:0] fill_q;
    logic [AGE_W-1:0]  age_q;
    logic              armed;

    assign armed = (fill_q == FILL_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst)                   fill_q <= '0;
        else if (release_i)        fill_q <= '0;
        else if (shift_i && !armed) fill_q <= fill_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q   <= '0;
            stale_o <= 1'b0;
        end else if (shift_i) begin
            age_q   <= '0;
            stale_o <= 1'b0;
        end else if (release_i) begin
            age_q   <= '0;
        end else if (armed && !stale_o) begin
            if (age_q == AGE_W'(LIMIT - 1)) stale_o <= 1'b1;
            else                            age_q   <= age_q + 1'b1;
        end
    end

    // R9: a fresh serial edge always revives the chain
    assert_stale_clear_R9: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> !stale_o);

endmodule

// File: rtl/xbar_latch_bank.sv
module xbar_latch_bank
    import xbar_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_i,
    input  logic [ROWS*COLS-1:0] chain_i,
    output logic [ROWS*COLS-1:0] cells_o
);
    logic [COLS-1:0] row_q [ROWS];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        localparam int BASE = cell_index(r, 0, COLS);
        always_ff @(posedge clk) begin
            if (rst)         row_q[r] <= '0;
            else if (load_i) row_q[r] <= chain_i[BASE +: COLS];
        end
        assign cells_o[BASE +: COLS] = row_q[r];
    end

    // R6: without a transfer request the matrix keeps its value
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> $stable(cells_o));

endmodule

// File: rtl/xbar_cfg_top.sv
module xbar_cfg_top
    import xbar_pkg::*;
#(
    parameter int ROWS        = 16,
    parameter int COLS        = 16,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_LIMIT  = 1000000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk_i,
    input  logic                 ser_dat_i,
    input  logic                 xfer_n_i,
    output logic                 ser_dat_o,
    output logic [ROWS*COLS-1:0] connect_o,
    output logic                 stale_o
);
    localparam int CELLS = ROWS * COLS;

    ser_pins_t        raw;
    ser_ctl_t         ctl;
    logic [CELLS-1:0] chain;
    logic             load;

    assign raw  = '{sclk: ser_clk_i, sdat: ser_dat_i, strobe_n: xfer_n_i};
    assign load = ctl.strobe_low & ~stale_o;

    xbar_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (raw),
        .ctl_o  (ctl)
    );

    xbar_shift_chain #(.DEPTH(CELLS)) u_chain (
        .clk     (clk),
        .rst     (rst),
        .shift_i (ctl.shift),
        .bit_i   (ctl.shift_bit),
        .chain_o (chain),
        .tail_o  (ser_dat_o)
    );

    xbar_hold_timer #(.DEPTH(CELLS), .LIMIT(HOLD_LIMIT)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .shift_i   (ctl.shift),
        .release_i (ctl.release_evt),
        .stale_o   (stale_o)
    );

    xbar_latch_bank #(.ROWS(ROWS), .COLS(COLS)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .chain_i (chain),
        .cells_o (connect_o)
    );

    // R8: an expired chain never reaches the matrix
    assert_blocked_R8: assert property (@(posedge clk) disable iff (rst)
        stale_o |=> $stable(connect_o));
    // R1: reset opens every switch and clears the outputs
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (connect_o == '0 && !stale_o && !ser_dat_o));

endmodule

// File: tb/tb_xbar_cfg_top.sv
`timescale 1ns/1ps
module tb_xbar_cfg_top;
    localparam int LIMIT = 300;
    localparam int N     = 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, sdat = 1'b0, strb = 1'b1;
    logic sout, stale;
    logic [N-1:0] conn;

    always #2.5 clk = ~clk;

    xbar_cfg_top #(.ROWS(16), .COLS(16), .SYNC_STAGES(2), .HOLD_LIMIT(LIMIT)) dut (
        .clk(clk), .rst(rst), .ser_clk_i(sclk), .ser_dat_i(sdat), .xfer_n_i(strb),
        .ser_dat_o(sout), .connect_o(conn), .stale_o(stale)
    );

    int vectors = 0, misses = 0;
    bit finished = 0;

    // ---------------- behavioural reference model ----------------
    logic [1:0] q_sc, q_sd, q_st;
    logic m_scd, m_std, m_stale;
    logic [N-1:0] m_sr, m_lat;
    int m_fill, m_age;
    logic sc, dd, st, rise, rel, armed, old_stale;

    always @(posedge clk) begin
        if (rst) begin
            q_sc = 2'b11; q_sd = 2'b00; q_st = 2'b11;
            m_scd = 1; m_std = 1; m_sr = '0; m_lat = '0;
            m_fill = 0; m_age = 0; m_stale = 0;
        end else begin
            sc = q_sc[1]; dd = q_sd[1]; st = q_st[1];
            rise = sc & ~m_scd;
            rel = st & ~m_std;
            armed = (m_fill == N);
            old_stale = m_stale;
            if (!st && !old_stale) m_lat = m_sr;
            if (rise) m_sr = {m_sr[N-2:0], dd};
            if (rel) m_fill = 0;
            else if (rise && m_fill != N) m_fill++;
            if (rise) begin m_age = 0; m_stale = 0; end
            else if (rel) m_age = 0;
            else if (armed && !old_stale) begin
                if (m_age == LIMIT - 1) m_stale = 1; else m_age++;
            end
            q_sc = {q_sc[0], sclk}; q_sd = {q_sd[0], sdat}; q_st = {q_st[0], strb};
            m_scd = sc; m_std = st;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            vectors++;
            if (conn !== m_lat) begin
                misses++;
                $display("FAIL R5/R6 matrix act=%h exp=%h", conn, m_lat);
            end
            if (sout !== m_sr[N-1]) begin
                misses++;
                $display("FAIL R4 sout act=%b exp=%b", sout, m_sr[N-1]);
            end
            if (stale !== m_stale) begin
                misses++;
                $display("FAIL R7 stale act=%b exp=%b", stale, m_stale);
            end
        end
    end

    // ---------------- scenario helpers ----------------
    logic hist [$];

    task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        logic e;
        @(negedge clk); sdat = b; sclk = 0;
        @(negedge clk);
        @(negedge clk); sclk = 1;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        hist.push_back(b);
        e = (hist.size() >= N) ? hist[hist.size() - N] : 1'b0;
        check(sout === e, "R4 delayed serial out", N'(sout), N'(e));
    endtask

    // frame f indexed row*16+col; sent row 15..0, col 15..0
    task automatic load_frame(input logic [N-1:0] f);
        for (int r = 15; r >= 0; r--)
            for (int c = 15; c >= 0; c--)
                send_bit(f[r*16 + c]);
    endtask

    task automatic pulse_strobe();
        @(negedge clk); strb = 0;
        repeat (3) @(negedge clk);
        strb = 1;
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [N-1:0] rand_frame();
        logic [N-1:0] f;
        for (int i = 0; i < N / 32; i++) f[i*32 +: 32] = $urandom;
        return f;
    endfunction

    logic [N-1:0] fa, fb, fc, fd, exp_lvl;
    logic [15:0] extra;

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(conn === '0, "R1 matrix cleared", conn, '0);
        check(stale === 0 && sout === 0, "R1 flags cleared", N'({stale, sout}), '0);

        // R3: single corner bits
        fa = '0; fa[15*16 + 15] = 1'b1;
        load_frame(fa); pulse_strobe();
        check(conn === fa, "R3 first bit -> row15/col15", conn, fa);
        fa = '0; fa[0] = 1'b1;
        load_frame(fa); pulse_strobe();
        check(conn === fa, "R3 last bit -> row0/col0", conn, fa);

        // R3: random matrix
        fa = rand_frame();
        load_frame(fa); pulse_strobe();
        check(conn === fa, "R3 random mapping", conn, fa);

        // R6: load without strobe; matrix must hold (R4 checked per bit)
        fb = rand_frame();
        load_frame(fb);
        check(conn === fa, "R6 hold without strobe", conn, fa);
        pulse_strobe();
        check(conn === fb, "R3 second random mapping", conn, fb);

        // R7/R8: let the filled chain expire
        fc = rand_frame();
        load_frame(fc);
        repeat (LIMIT + 10) @(negedge clk);
        check(stale === 1'b1, "R7 stale after hold limit", N'(stale), N'(1));
        pulse_strobe();
        check(conn === fb, "R8 transfer blocked when stale", conn, fb);
        send_bit(1'b0);
        check(stale === 1'b0, "R9 serial edge clears stale", N'(stale), '0);

        // prompt transfer inside the window
        fd = rand_frame();
        load_frame(fd);
        repeat (LIMIT / 3) @(negedge clk);
        pulse_strobe();
        check(conn === fd, "R7 transfer inside window", conn, fd);
        check(stale === 1'b0, "R7 no stale inside window", N'(stale), '0);

        // R5: strobe held low, matrix follows newly shifted bits
        @(negedge clk); strb = 0;
        extra = 16'($urandom);
        exp_lvl = fd;
        for (int i = 15; i >= 0; i--) begin
            send_bit(extra[i]);
            exp_lvl = {exp_lvl[N-2:0], extra[i]};
        end
        repeat (3) @(negedge clk);
        check(conn === exp_lvl, "R5 level-following transfer", conn, exp_lvl);
        strb = 1;
        repeat (5) @(negedge clk);

        // R2: no serial edges, strobe pulse reflects unchanged chain
        repeat (50) @(negedge clk);
        pulse_strobe();
        check(conn === exp_lvl, "R2 chain static without edges", conn, exp_lvl);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            misses++;
            $display("FAIL watchdog act=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule